// File: doc/BRIEF.md
# Locality Interrupt Enable and Status Unit

This block keeps one interrupt enable word and one interrupt status word for each access locality of a security-module host interface. Event pulses arrive from the locality arbiter and the command engine, each one tagged with a locality and a set of source flags. A flag is latched into that locality's status word only if the locality's global enable bit is set and the matching source enable bit is set too. Every latched flag raises a single level interrupt output. The output is active-high and stays high until it is cleared.

Software reads and writes the registers through a simple word access port. The port carries a locality number, a register selector, a byte-lane strobe and the data. A write changes anything only when it comes from the locality that currently owns the interface. The status word is write-one-to-clear. The interrupt output drops when a write from the owning locality clears that locality's status word to zero. A third selector reads a fixed interrupt vector number, set by a parameter, and writes to it are ignored. Reads are combinational from the stored state, so a write shows up on `rd_data` in the cycle after the clock edge that took it.

Top module: `lirq_unit`

## Requirements
- R1: After reset, every locality's enable word reads 0x0000_0008 (polarity field in bits [4:3] = 01, all else 0), every status word reads 0, and `irq` is low.
- R2: A full-width enable write from the owning locality stores only bit 31 (global enable), bits [4:3] (polarity), and source bits 7, 2, 1 and 0; all other bits read back 0.
- R3: Byte strobe `acc_be[i]` gates byte i of the 32-bit word on both enable and status writes; bytes whose strobe is 0 keep their value.
- R4: A write to enable or status is ignored when `active_valid` is 0 or `acc_loc` differs from `active_loc`.
- R5: `evt_src` bit 0 maps to status bit 0 (data available), bit 1 to bit 1 (status valid), bit 2 to bit 2 (locality changed), and bit 3 to bit 7 (command ready). A source latches into the status word of `evt_loc` one cycle after the pulse only if that locality's enable bit 31 and the matching source enable bit are both 1.
- R6: `irq` goes high in the cycle after any source latches, and it stays high while nothing clears it.
- R7: Events whose `evt_loc` is NUM_LOC or above leave every status word and `irq` unchanged.
- R8: A status write from the owning locality clears the status bits (0, 1, 2, 7) where the write data and the lane strobe are 1. Other bit positions are not affected.
- R9: `irq` drops in the cycle after a status write that clears at least one pending bit and leaves the owning locality's status at zero, even if other localities still hold status bits. A partial clear keeps `irq` high. If a source latches in the same cycle, `irq` stays high.
- R10: Selector 1 reads VEC_NUM for any valid locality, and writes to selector 1 change no state.
- R11: A read with selector 3, or with `acc_loc` of NUM_LOC or above, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_valid | input | 1 | A locality currently owns the interface |
| active_loc | input | LOC_W | Owning locality number |
| evt_valid | input | 1 | Event pulse strobe |
| evt_loc | input | LOC_W | Locality the event belongs to |
| evt_src | input | 4 | Event source flags (data available, status valid, locality changed, command ready) |
| acc_wr | input | 1 | Register write strobe |
| acc_loc | input | LOC_W | Locality of the access |
| acc_sel | input | 2 | Register select: 0 enable, 1 vector, 2 status, 3 unmapped |
| acc_be | input | 4 | Byte-lane write strobe |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed locality and register |
| irq | output | 1 | Active-high interrupt level |

## Verification
A wrongly latched or lost status bit shows on `rd_data` one cycle after the event, at the latest, whenever the bench has that locality and status selected. The bench compares `rd_data` and `irq` against a behavioural model on every clock, so a stuck or missed `irq` transition is reported in the cycle it happens. Corrupted enable bits do not show up at once. They appear only when a later event is gated wrongly, so directed sequences write an enable word, read it back, and then fire events against it. A random phase with ownership changes covers the same-cycle clear and event cases.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   typedef logic [31:0] lirq_word_t;

   localparam logic [1:0] SEL_EN  = 2'd0;
   localparam logic [1:0] SEL_VEC = 2'd1;
   localparam logic [1:0] SEL_ST  = 2'd2;

   localparam lirq_word_t EN_KEEP = 32'h8000_009F;
   localparam lirq_word_t ST_KEEP = 32'h0000_0087;
   localparam lirq_word_t EN_RST  = 32'h0000_0008;
   localparam int         GEN_BIT = 31;

   function automatic lirq_word_t map_src(input logic [3:0] src);
      lirq_word_t w;
      w = '0;
      w[0] = src[0];
      w[1] = src[1];
      w[2] = src[2];
      w[7] = src[3];
      return w;
   endfunction
endpackage

// File: rtl/lirq_loc_bank.sv
module lirq_loc_bank
   import lirq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en_reg,
   input  logic       wr_st_reg,
   input  lirq_word_t lane_mask,
   input  lirq_word_t wdata,
   input  logic       evt_hit,
   input  lirq_word_t evt_bits,
   output lirq_word_t en_q,
   output lirq_word_t st_q,
   output logic       latched,
   output logic       emptied
);
   lirq_word_t gated, clr, st_d, en_d;

   always_comb begin
      gated = (evt_hit && en_q[GEN_BIT]) ? (evt_bits & en_q & ST_KEEP) : '0;
      clr   = wr_st_reg ? (wdata & lane_mask & ST_KEEP) : '0;
      st_d  = (st_q & ~clr) | gated;
      en_d  = wr_en_reg ? ((en_q & ~lane_mask) | (wdata & lane_mask & EN_KEEP)) : en_q;
   end

   assign latched = |gated;
   assign emptied = wr_st_reg && (|clr) && (|(st_q & ST_KEEP)) && (st_d == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= EN_RST;
         st_q <= '0;
      end else begin
         en_q <= en_d;
         st_q <= st_d;
      end
   end
endmodule

// File: rtl/lirq_line.sv
module lirq_line #(
   parameter int NUM_LOC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LOC-1:0] set_vec,
   input  logic [NUM_LOC-1:0] clr_vec,
   output logic               irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        irq <= 1'b0;
      else if (|set_vec) irq <= 1'b1;
      else if (|clr_vec) irq <= 1'b0;
   end
endmodule

// File: rtl/lirq_rd_mux.sv
module lirq_rd_mux
   import lirq_pkg::*;
#(
   parameter int NUM_LOC = 5,
   parameter int LOC_W   = 3,
   parameter int VEC_NUM = 11
) (
   input  logic [LOC_W-1:0]      loc,
   input  logic [1:0]            sel,
   input  logic [NUM_LOC*32-1:0] en_flat,
   input  logic [NUM_LOC*32-1:0] st_flat,
   output lirq_word_t            rd
);
   always_comb begin
      rd = '0;
      for (int i = 0; i < NUM_LOC; i++) begin
         if (loc == LOC_W'(i)) begin
            case (sel)
               SEL_EN:  rd = en_flat[i*32 +: 32];
               SEL_VEC: rd = 32'(VEC_NUM);
               SEL_ST:  rd = st_flat[i*32 +: 32];
               default: rd = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/lirq_unit.sv
module lirq_unit
   import lirq_pkg::*;
#(
   parameter int NUM_LOC = 5,
   parameter int LOC_W   = 3,
   parameter int VEC_W   = 4,
   parameter int VEC_NUM = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_valid,
   input  logic [LOC_W-1:0] active_loc,
   input  logic             evt_valid,
   input  logic [LOC_W-1:0] evt_loc,
   input  logic [3:0]       evt_src,
   input  logic             acc_wr,
   input  logic [LOC_W-1:0] acc_loc,
   input  logic [1:0]       acc_sel,
   input  logic [3:0]       acc_be,
   input  logic [31:0]      acc_wdata,
   output logic [31:0]      rd_data,
   output logic             irq
);
   localparam int LANES = 4;

   if (NUM_LOC < 1 || NUM_LOC > (1 << LOC_W)) begin : g_chk_loc
      $error("NUM_LOC must fit in LOC_W bits");
   end
   if (VEC_NUM < 0 || VEC_NUM >= (1 << VEC_W)) begin : g_chk_vec
      $error("VEC_NUM must fit in VEC_W bits");
   end

   lirq_word_t            lane_mask;
   lirq_word_t            evt_bits;
   logic                  owner_wr;
   logic [NUM_LOC-1:0]    latched, emptied;
   logic [NUM_LOC*32-1:0] en_flat, st_flat;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign lane_mask[b*8 +: 8] = {8{acc_be[b]}};
   end

   assign evt_bits = map_src(evt_src);
   assign owner_wr = acc_wr && active_valid && (acc_loc == active_loc);

   for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
      logic hit_acc, hit_evt;
      assign hit_acc = owner_wr && (acc_loc == LOC_W'(i));
      assign hit_evt = evt_valid && (evt_loc == LOC_W'(i));

      lirq_loc_bank u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en_reg (hit_acc && (acc_sel == SEL_EN)),
         .wr_st_reg (hit_acc && (acc_sel == SEL_ST)),
         .lane_mask (lane_mask),
         .wdata     (acc_wdata),
         .evt_hit   (hit_evt),
         .evt_bits  (evt_bits),
         .en_q      (en_flat[i*32 +: 32]),
         .st_q      (st_flat[i*32 +: 32]),
         .latched   (latched[i]),
         .emptied   (emptied[i])
      );
   end

   lirq_line #(.NUM_LOC(NUM_LOC)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (latched),
      .clr_vec (emptied),
      .irq     (irq)
   );

   lirq_rd_mux #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VEC_NUM(VEC_NUM)) u_rd (
      .loc     (acc_loc),
      .sel     (acc_sel),
      .en_flat (en_flat),
      .st_flat (st_flat),
      .rd      (rd_data)
   );
endmodule

// File: rtl/lirq_unit_chk.sv
module lirq_unit_chk #(
   parameter int NUM_LOC = 5,
   parameter int LOC_W   = 3,
   parameter int VEC_NUM = 11
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  active_valid,
   input logic [LOC_W-1:0]      active_loc,
   input logic                  evt_valid,
   input logic [LOC_W-1:0]      evt_loc,
   input logic [3:0]            evt_src,
   input logic                  acc_wr,
   input logic [LOC_W-1:0]      acc_loc,
   input logic [1:0]            acc_sel,
   input logic [31:0]           rd_data,
   input logic                  irq,
   input logic [NUM_LOC*32-1:0] en_flat,
   input logic [NUM_LOC*32-1:0] st_flat
);
   logic [31:0] ev_en, ev_req;
   logic        ev_ok, acc_ok, owner;

   always_comb begin
      ev_en = '0;
      ev_ok = 1'b0;
      acc_ok = 1'b0;
      for (int i = 0; i < NUM_LOC; i++) begin
         if (evt_loc == LOC_W'(i)) begin
            ev_en = en_flat[i*32 +: 32];
            ev_ok = 1'b1;
         end
         if (acc_loc == LOC_W'(i)) acc_ok = 1'b1;
      end
      ev_req = {24'b0, evt_src[3], 4'b0, evt_src[2:0]};
   end

   assign owner = acc_wr && active_valid && (acc_loc == active_loc);

   // R6: a gated event raises the line on the next edge
   p_evt_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && ev_ok && ev_en[31] && |(ev_req & ev_en)) |=> irq);

   // R6: the line rises only after an event pulse
   p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(evt_valid));

   // R9: the line falls only after an owner status write
   p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(owner && (acc_sel == 2'd2)));

   // R7: events for missing localities touch no status word
   p_badloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !ev_ok && !(acc_wr && acc_sel == 2'd2)) |=> $stable(st_flat));

   // R10: vector selector reads the configured number
   p_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sel == 2'd1 && acc_ok) |-> (rd_data == 32'(VEC_NUM)));

   for (genvar i = 0; i < NUM_LOC; i++) begin : g_hold
      // R4: enable word changes only on an owner write to it
      p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(owner && acc_loc == LOC_W'(i) && acc_sel == 2'd0) |=> $stable(en_flat[i*32 +: 32]));
   end
endmodule

bind lirq_unit lirq_unit_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VEC_NUM(VEC_NUM)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .active_valid (active_valid),
   .active_loc   (active_loc),
   .evt_valid    (evt_valid),
   .evt_loc      (evt_loc),
   .evt_src      (evt_src),
   .acc_wr       (acc_wr),
   .acc_loc      (acc_loc),
   .acc_sel      (acc_sel),
   .rd_data      (rd_data),
   .irq          (irq),
   .en_flat      (en_flat),
   .st_flat      (st_flat)
);

// File: tb/lirq_unit_tb.sv
`timescale 1ns/100ps
module lirq_unit_tb;
   localparam int NUM_LOC = 5;
   localparam int LOC_W   = 3;
   localparam int VEC_NUM = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             active_valid = 1'b0;
   logic [LOC_W-1:0] active_loc = '0;
   logic             evt_valid = 1'b0;
   logic [LOC_W-1:0] evt_loc = '0;
   logic [3:0]       evt_src = '0;
   logic             acc_wr = 1'b0;
   logic [LOC_W-1:0] acc_loc = '0;
   logic [1:0]       acc_sel = '0;
   logic [3:0]       acc_be = '0;
   logic [31:0]      acc_wdata = '0;
   logic [31:0]      rd_data;
   logic             irq;

   int checks = 0;
   int errors = 0;
   int cyc_n  = 0;
   bit done   = 0;

   int unsigned m_en [8];
   int unsigned m_st [8];
   bit          m_irq;

   always #2.5 clk = ~clk;

   lirq_unit #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VEC_NUM(VEC_NUM)) u_dut (
      .clk(clk), .rst_n(rst_n), .active_valid(active_valid), .active_loc(active_loc),
      .evt_valid(evt_valid), .evt_loc(evt_loc), .evt_src(evt_src),
      .acc_wr(acc_wr), .acc_loc(acc_loc), .acc_sel(acc_sel), .acc_be(acc_be),
      .acc_wdata(acc_wdata), .rd_data(rd_data), .irq(irq));

   function automatic int unsigned lanes(input logic [3:0] be);
      int unsigned m = 0;
      for (int b = 0; b < 4; b++) if (be[b]) m = m | (32'hFF << (8*b));
      return m;
   endfunction

   function automatic int unsigned model_rd();
      if (int'(acc_loc) >= NUM_LOC) return 0;
      case (acc_sel)
         2'd0: return m_en[acc_loc];
         2'd1: return VEC_NUM;
         2'd2: return m_st[acc_loc];
         default: return 0;
      endcase
   endfunction

   task automatic model_step();
      int unsigned nen[8], nst[8], g, c, ln;
      bit owner, setany, clrz;
      for (int l = 0; l < 8; l++) begin nen[l] = m_en[l]; nst[l] = m_st[l]; end
      ln = lanes(acc_be);
      owner = acc_wr && active_valid && acc_loc == active_loc && int'(acc_loc) < NUM_LOC;
      c = 0; setany = 0; clrz = 0;
      if (owner && acc_sel == 2'd2) begin
         c = acc_wdata & ln & 32'h87;
         nst[acc_loc] = m_st[acc_loc] & ~c;
      end
      if (owner && acc_sel == 2'd0)
         nen[acc_loc] = (m_en[acc_loc] & ~ln) | (acc_wdata & ln & 32'h8000_009F);
      if (evt_valid && int'(evt_loc) < NUM_LOC && m_en[evt_loc][31]) begin
         g = (evt_src[0] ? 1 : 0) | (evt_src[1] ? 2 : 0) | (evt_src[2] ? 4 : 0) | (evt_src[3] ? 128 : 0);
         g = g & m_en[evt_loc];
         nst[evt_loc] = nst[evt_loc] | g;
         setany = (g != 0);
      end
      if (owner && acc_sel == 2'd2 && c != 0 && (m_st[acc_loc] & 32'h87) != 0 && nst[acc_loc] == 0)
         clrz = 1;
      if (setany) m_irq = 1;
      else if (clrz) m_irq = 0;
      for (int l = 0; l < 8; l++) begin m_en[l] = nen[l]; m_st[l] = nst[l]; end
   endtask

   task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h (cycle %0d)", tag, act, exp, cyc_n);
      end
   endtask

   // one clock: update model, advance, compare both outputs
   task automatic cyc(input string tag);
      model_step();
      @(posedge clk);
      @(negedge clk);
      cyc_n++;
      chk({tag, " rd"}, rd_data, model_rd());
      chk({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
   endtask

   task automatic idle();
      evt_valid = 0; acc_wr = 0; acc_be = 4'hF;
   endtask

   task automatic wr(input string tag, input int l, input logic [1:0] s, input logic [3:0] be, input logic [31:0] d);
      acc_wr = 1; acc_loc = LOC_W'(l); acc_sel = s; acc_be = be; acc_wdata = d;
      cyc(tag);
      idle();
   endtask

   task automatic rd(input string tag, input int l, input logic [1:0] s, input logic [31:0] exp);
      acc_loc = LOC_W'(l); acc_sel = s;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic ev(input string tag, input int l, input logic [3:0] src);
      evt_valid = 1; evt_loc = LOC_W'(l); evt_src = src;
      cyc(tag);
      idle();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int l = 0; l < 8; l++) begin m_en[l] = (l < NUM_LOC) ? 8 : 0; m_st[l] = 0; end
      m_irq = 0;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      for (int l = 0; l < NUM_LOC; l++) begin
         rd("R1 enable reset", l, 2'd0, 32'h8);
         rd("R1 status reset", l, 2'd2, 32'h0);
      end
      chk("R1 irq reset", {31'b0, irq}, 0);

      active_valid = 1; active_loc = 0;
      wr("R2 full enable write", 0, 2'd0, 4'hF, 32'hFFFF_FFFF);
      rd("R2 enable kept bits", 0, 2'd0, 32'h8000_009F);
      wr("R4 non-owner enable write", 1, 2'd0, 4'hF, 32'hFFFF_FFFF);
      rd("R4 non-owner enable", 1, 2'd0, 32'h8);
      active_valid = 0;
      wr("R4 no owner write", 0, 2'd0, 4'hF, 32'h0);
      rd("R4 no owner enable", 0, 2'd0, 32'h8000_009F);
      active_valid = 1;
      wr("R3 byte0 enable write", 0, 2'd0, 4'b0001, 32'h0);
      rd("R3 byte0 only", 0, 2'd0, 32'h8000_0000);
      wr("R2 restore enable", 0, 2'd0, 4'hF, 32'h8000_009F);

      ev("R5 event all sources", 0, 4'hF);
      rd("R5 status latched", 0, 2'd2, 32'h87);
      chk("R6 irq raised", {31'b0, irq}, 1);
      ev("R5 event without global enable", 1, 4'hF);
      rd("R5 loc1 gated", 1, 2'd2, 32'h0);

      wr("R9 partial clear", 0, 2'd2, 4'hF, 32'h1);
      rd("R8 status after partial", 0, 2'd2, 32'h86);
      chk("R9 irq stays", {31'b0, irq}, 1);
      wr("R4 non-owner clear", 2, 2'd2, 4'hF, 32'hFFFF_FFFF);
      wr("R3 byte1 clear only", 0, 2'd2, 4'b0010, 32'hFFFF_FFFF);
      rd("R3 status unchanged", 0, 2'd2, 32'h86);
      wr("R8 clear all", 0, 2'd2, 4'b0001, 32'hFFFF_FF7F);
      rd("R8 bit7 kept", 0, 2'd2, 32'h80);
      wr("R9 final clear", 0, 2'd2, 4'hF, 32'h80);
      chk("R9 irq dropped", {31'b0, irq}, 0);

      ev("R7 invalid loc 5", 5, 4'hF);
      ev("R7 invalid loc 7", 7, 4'hF);
      chk("R7 irq unchanged", {31'b0, irq}, 0);
      rd("R11 invalid loc read", 6, 2'd0, 32'h0);
      rd("R11 unmapped sel", 0, 2'd3, 32'h0);

      wr("R10 vector write", 0, 2'd1, 4'hF, 32'h0);
      rd("R10 vector read", 0, 2'd1, VEC_NUM);
      rd("R10 vector read loc3", 3, 2'd1, VEC_NUM);

      wr("R5 source enable only bit0", 0, 2'd0, 4'hF, 32'h8000_0001);
      ev("R5 masked source", 0, 4'b1000);
      rd("R5 masked stays zero", 0, 2'd2, 32'h0);
      ev("R5 unmasked source", 0, 4'b1001);
      rd("R5 only bit0", 0, 2'd2, 32'h1);
      // clear and new event in same cycle
      acc_wr = 1; acc_loc = 0; acc_sel = 2'd2; acc_be = 4'hF; acc_wdata = 32'h1;
      evt_valid = 1; evt_loc = 0; evt_src = 4'b0001;
      cyc("R9 clear with event");
      idle();
      chk("R9 event wins", {31'b0, irq}, 1);
      wr("R9 clear after", 0, 2'd2, 4'hF, 32'h1);
      chk("R9 irq low again", {31'b0, irq}, 0);

      // random phase, compared against the model every clock
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 15) == 0) begin
            active_valid = ($urandom_range(0, 7) != 0);
            active_loc = LOC_W'($urandom_range(0, 5));
         end
         evt_valid = ($urandom_range(0, 3) == 0);
         evt_loc = LOC_W'($urandom_range(0, 6));
         evt_src = 4'($urandom);
         acc_wr = ($urandom_range(0, 2) == 0);
         acc_loc = ($urandom_range(0, 1) == 0) ? active_loc : LOC_W'($urandom_range(0, 7));
         acc_sel = 2'($urandom);
         acc_be = 4'($urandom);
         acc_wdata = $urandom;
         if ($urandom_range(0, 3) == 0) acc_wdata[31] = 1'b1;
         cyc("R5 R8 R9 random");
      end
      idle();

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule